// File: doc/BRIEF.md
# Speed Error Fuzzifier

This block is the front end of a fuzzy speed regulator. Each time a sample strobe arrives it takes a target speed word and a measured speed word. Both are signed integers in rpm. It subtracts them to get the tracking error. It also keeps the error from the previous strobe, so it can form the change of error. Both quantities are then graded against five linguistic sets: negative-big, negative, zero, positive and positive-big.

The error scale has its set peaks at -750, -500, 0, +500 and +750. The change-of-error scale has its peaks at -150, -75, 0, +75 and +150. The two end sets are shoulders: they saturate at full membership beyond the outer peak. The three inner sets are triangles. Every degree is an unsigned 8-bit value, where 255 means full membership. The ten degrees feed a downstream min/max rule stage. They are registered and announced by a one-cycle valid pulse.

Top module: `fuzz_front`

## Requirements
- R1: The error is the target speed minus the measured speed, both taken at the strobe.
- R2: The change of error is the current error minus the error captured at the previous strobe.
- R3: After reset the stored previous error is zero, so the first change of error equals the first error.
- R4: The error degrees use peaks -750, -500, 0, 500, 750. For x between adjacent peaks p_k <= x < p_k+1, set k+1 gets floor((x-p_k)*255/(p_k+1-p_k)) and set k gets 255 minus that value.
- R5: The change-of-error degrees use the same rule with peaks -150, -75, 0, 75, 150.
- R6: For each input, at most two sets are nonzero and the degrees sum to exactly 255.
- R7: An input at or below the lowest peak gives 255 in negative-big and 0 elsewhere. An input at or above the highest peak gives 255 in positive-big and 0 elsewhere.
- R8: mu_vld is high for exactly one cycle, on the second rising edge after the edge that sampled the strobe. The degree outputs change only at that edge and hold their value otherwise.
- R9: Speed inputs presented while the strobe is low have no effect on the outputs or on the stored previous error.
- R10: Each degree vector is packed as 5 fields of 8 bits. Field k occupies bits [8k+7:8k], with k=0 negative-big, 1 negative, 2 zero, 3 positive and 4 positive-big. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, one cycle per control period |
| ref_spd | input | 12 | Signed target speed, rpm |
| meas_spd | input | 12 | Signed measured speed, rpm |
| mu_vld | output | 1 | One-cycle pulse: degree outputs updated |
| err_mu | output | 40 | Five 8-bit error degrees |
| dlt_mu | output | 40 | Five 8-bit change-of-error degrees |

## Verification
The bench aims at inputs landing exactly on a peak. A segment selection that is off by one there would split membership between two sets instead of giving 255 to one. It drives values past both outer peaks, where a missing shoulder would wrap or fall to zero. It also drives the first sample after reset: a previous-error register left uninitialised would corrupt the first change of error. Between strobes the bench wiggles the speed inputs, which exposes a design that updates its history or outputs without a strobe. Several hundred random samples test the sum-to-255 and two-neighbour properties across all segments.

// File: rtl/fuzz_front.sv
module fuzz_front #(
  parameter int IN_W  = 12,
  parameter int MU_W  = 8,
  parameter int E_IN  = 500,
  parameter int E_OUT = 750,
  parameter int D_IN  = 75,
  parameter int D_OUT = 150
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_stb,
  input  logic signed [IN_W-1:0] ref_spd,
  input  logic signed [IN_W-1:0] meas_spd,
  output logic                   mu_vld,
  output logic [5*MU_W-1:0]      err_mu,
  output logic [5*MU_W-1:0]      dlt_mu
);

  localparam int MU_MAX = (1 << MU_W) - 1;
  localparam int EW = IN_W + 1;
  localparam int DW = IN_W + 2;

  logic signed [EW-1:0] err_now, err_q, err_prev;
  logic signed [DW-1:0] dlt_q;
  logic stg1;

  assign err_now = EW'(ref_spd) - EW'(meas_spd);

  function automatic logic [5*MU_W-1:0] grade(input int x, input int a, input int b);
    logic [5*MU_W-1:0] m;
    int u;
    m = '0;
    u = 0;
    if (x <= -b) begin
      m[0 +: MU_W] = MU_W'(MU_MAX);
    end else if (x < -a) begin
      u = (x + b) * MU_MAX / (b - a);
      m[1*MU_W +: MU_W] = MU_W'(u);
      m[0*MU_W +: MU_W] = MU_W'(MU_MAX - u);
    end else if (x < 0) begin
      u = (x + a) * MU_MAX / a;
      m[2*MU_W +: MU_W] = MU_W'(u);
      m[1*MU_W +: MU_W] = MU_W'(MU_MAX - u);
    end else if (x < a) begin
      u = x * MU_MAX / a;
      m[3*MU_W +: MU_W] = MU_W'(u);
      m[2*MU_W +: MU_W] = MU_W'(MU_MAX - u);
    end else if (x < b) begin
      u = (x - a) * MU_MAX / (b - a);
      m[4*MU_W +: MU_W] = MU_W'(u);
      m[3*MU_W +: MU_W] = MU_W'(MU_MAX - u);
    end else begin
      m[4*MU_W +: MU_W] = MU_W'(MU_MAX);
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1     <= 1'b0;
      err_q    <= '0;
      dlt_q    <= '0;
      err_prev <= '0;
      mu_vld   <= 1'b0;
      err_mu   <= '0;
      dlt_mu   <= '0;
    end else begin
      stg1   <= smp_stb;
      mu_vld <= stg1;
      if (smp_stb) begin
        err_q    <= err_now;
        dlt_q    <= DW'(err_now) - DW'(err_prev);
        err_prev <= err_now;
      end
      if (stg1) begin
        err_mu <= grade(int'(err_q), E_IN, E_OUT);
        dlt_mu <= grade(int'(dlt_q), D_IN, D_OUT);
      end
    end
  end

  function automatic int sum5(input logic [5*MU_W-1:0] v);
    int s;
    s = 0;
    for (int k = 0; k < 5; k++) s += int'(v[k*MU_W +: MU_W]);
    return s;
  endfunction

  function automatic logic [4:0] nz5(input logic [5*MU_W-1:0] v);
    logic [4:0] z;
    for (int k = 0; k < 5; k++) z[k] = |v[k*MU_W +: MU_W];
    return z;
  endfunction

  a_r6_sum_full: assert property (@(posedge clk) disable iff (!rst_n)
    mu_vld |-> (sum5(err_mu) == MU_MAX && sum5(dlt_mu) == MU_MAX));

  a_r6_two_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mu_vld |-> ($countones(nz5(err_mu)) <= 2 && $countones(nz5(dlt_mu)) <= 2));

  a_r7_err_high: assert property (@(posedge clk) disable iff (!rst_n)
    (stg1 && int'(err_q) >= E_OUT) |=> err_mu[4*MU_W +: MU_W] == MU_W'(MU_MAX));

  a_r7_err_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stg1 && int'(err_q) <= -E_OUT) |=> err_mu[0 +: MU_W] == MU_W'(MU_MAX));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> ##2 mu_vld);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stg1 |=> ($stable(err_mu) && $stable(dlt_mu) && !mu_vld));

endmodule

// File: tb/sim_fuzz_front.sv
module sim_fuzz_front;
  localparam int PERIOD = 10;
  localparam int MW = 8;
  localparam int MAXD = 255;

  logic clk = 0, rst_n = 0, smp_stb = 0;
  logic signed [11:0] ref_spd = 0, meas_spd = 0;
  logic mu_vld;
  logic [5*MW-1:0] err_mu, dlt_mu;
  int checks = 0, fails = 0;
  int prev_err = 0;

  fuzz_front u0 (.clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .ref_spd(ref_spd),
                 .meas_spd(meas_spd), .mu_vld(mu_vld), .err_mu(err_mu), .dlt_mu(dlt_mu));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [5*MW-1:0] expect5(input int x, input int a, input int b);
    logic [5*MW-1:0] m;
    int p[5];
    int u;
    m = '0;
    p[0] = -b; p[1] = -a; p[2] = 0; p[3] = a; p[4] = b;
    if (x <= p[0]) m[0 +: MW] = 8'hFF;
    else if (x >= p[4]) m[4*MW +: MW] = 8'hFF;
    else
      for (int k = 0; k < 4; k++)
        if (x >= p[k] && x < p[k+1]) begin
          u = (x - p[k]) * MAXD / (p[k+1] - p[k]);
          m[(k+1)*MW +: MW] = 8'(u);
          m[k*MW +: MW] = 8'(MAXD - u);
        end
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [5*MW-1:0] act, input logic [5*MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample(input int r, input int m, input string tag);
    int e, d;
    logic [5*MW-1:0] ee, ed;
    e = r - m;
    d = e - prev_err;
    prev_err = e;
    ee = expect5(e, 500, 750);
    ed = expect5(d, 75, 150);
    @(negedge clk);
    ref_spd = 12'(r); meas_spd = 12'(m); smp_stb = 1;
    @(negedge clk);
    smp_stb = 0;
    ref_spd = 12'($urandom_range(0, 4095)); meas_spd = 12'($urandom_range(0, 4095));
    check(mu_vld == 0, {"R8 early valid ", tag}, {39'b0, mu_vld}, '0);
    @(negedge clk);
    check(mu_vld == 1, {"R8 valid ", tag}, {39'b0, mu_vld}, 40'd1);
    check(err_mu == ee, {"R1 R4 err ", tag}, err_mu, ee);
    check(dlt_mu == ed, {"R2 R5 delta ", tag}, dlt_mu, ed);
    ref_spd = 12'($urandom_range(0, 4095)); meas_spd = 12'($urandom_range(0, 4095));
    @(negedge clk);
    check(mu_vld == 0 && err_mu == ee && dlt_mu == ed, {"R8 R9 hold ", tag}, err_mu, ee);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(mu_vld == 0 && err_mu == 0 && dlt_mu == 0, "R10 reset state", err_mu, '0);
    rst_n = 1;
    sample(300, 0, "R3 first delta equals error");
    sample(800, 300, "R4 peak +500");
    sample(0, 750, "R7 low shoulder -750");
    sample(100, 100, "R4 zero peak");
    sample(1500, 0, "R7 high shoulder beyond");
    sample(-1400, 100, "R7 low shoulder beyond");
    sample(250, 0, "R4 midpoint 250");
    sample(325, 0, "R5 delta +75");
    sample(400, 0, "R5 delta +75 again");
    sample(400, 0, "R5 zero delta");
    for (int i = 0; i < 400; i++) begin
      int r, m;
      r = $urandom_range(0, 3000) - 1500;
      m = (i % 3 == 0) ? r - ($urandom_range(0, 400) - 200) : $urandom_range(0, 3000) - 1500;
      if (m > 2047) m = 2047;
      if (m < -2047) m = -2047;
      sample(r, m, "R6 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule